// File: doc/BRIEF.md
# Relative Branch Resolver

This block resolves a conditional relative branch for an 8-bit processor core. For each request it receives:

- the branch opcode;
- the four condition flags;
- the program counter, already advanced past the displacement byte;
- the signed 8-bit displacement.

From these it decides whether the branch is taken and produces the next program counter. For the branch-to-subroutine opcode it also raises a request to push a return address, and it supplies that address. Any opcode outside the branch group is flagged invalid and is never taken.

Requests arrive on a valid/ready stream and leave on a second valid/ready stream through a single register stage. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A held result therefore stalls the input side. Instruction fetch and the stack write itself belong to neighbouring blocks.

Top module: `rel_branch_unit`

## Requirements
- R1: A taken branch gives `out_next_pc` = `in_pc` + sign-extended `in_disp`, modulo 2^16. For example, 0xFFF0 + 0x7F gives 0x006F, and 0x0005 + 0x80 gives 0xFF85.
- R2: When a branch is not taken, `out_next_pc` equals `in_pc`. `out_ret_addr` always equals `in_pc`.
- R3: Flags are packed as `in_flags[3]`=N, `[2]`=Z, `[1]`=V, `[0]`=C. Opcode 0x20 is always taken and 0x21 is never taken.
- R4: The unsigned and carry group is decided as follows:
  - 0x22 is taken when (C|Z)=0, and 0x23 when (C|Z)=1.
  - 0x24 is taken when C=0, and 0x25 when C=1.
- R5: The single-flag group is decided as follows:
  - 0x26 is taken when Z=0, and 0x27 when Z=1.
  - 0x28 is taken when V=0, and 0x29 when V=1.
  - 0x2A is taken when N=0, and 0x2B when N=1.
- R6: The signed group is decided as follows:
  - 0x2C is taken when (N^V)=0, and 0x2D when (N^V)=1.
  - 0x2E is taken when (Z|(N^V))=0, and 0x2F when it is 1.
- R7: Opcode 0x8D is always taken and sets `out_push`. Every other opcode clears `out_push`.
- R8: Any opcode other than 0x20 to 0x2F and 0x8D sets `out_invalid`, with `out_taken`=0, `out_push`=0 and `out_next_pc`=`in_pc`. Valid opcodes clear `out_invalid`.
- R9: While `out_valid` is high and `out_ready` is low, every output holds its value. `in_ready` equals (!`out_valid` || `out_ready`). Results leave in the order their requests were accepted.
- R10: During and directly after reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_opcode | input | 8 | Branch opcode |
| in_flags | input | 4 | {N,Z,V,C} |
| in_pc | input | 16 | PC past the displacement byte |
| in_disp | input | 8 | Signed displacement |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts result |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 16 | Next program counter |
| out_push | output | 1 | Return-address push request |
| out_ret_addr | output | 16 | Return address to push |
| out_invalid | output | 1 | Opcode outside the branch group |

## Verification
Loading a new request and handing the previous result downstream can happen on the same edge, whenever `out_valid`, `out_ready` and `in_valid` are all high. Random stall patterns on both streams, drawn from a fixed seed, create many such edges. They also create long holds and idle gaps. Each consumed result is matched in order against a queue of expected results, which the bench computes from the requirements. Over a stall, the held outputs are compared from one cycle to the next, so a dropped, duplicated or overwritten result shows up as a mismatch.

// File: rtl/brc_pkg.sv
package brc_pkg;
  // flag bit positions inside the packed flag input
  localparam int FLG_C = 0;
  localparam int FLG_V = 1;
  localparam int FLG_Z = 2;
  localparam int FLG_N = 3;
  localparam int FLG_W = 4;

  // opcode group for conditional relative branches (upper nibble)
  localparam logic [3:0] REL_GROUP = 4'h2;
  // branch to subroutine
  localparam logic [7:0] SUBR_OP = 8'h8D;

  typedef struct packed {
    logic taken;
    logic push;
    logic invalid;
  } brc_decision_t;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0]  opcode,
  input  logic [FLG_W-1:0] flags,
  output brc_decision_t    dec
);
  localparam int N_BASE = 8;

  logic n_f, z_f, v_f, c_f, sgn_lt;
  logic [N_BASE-1:0] base;
  logic is_rel, is_sub;

  assign n_f = flags[FLG_N];
  assign z_f = flags[FLG_Z];
  assign v_f = flags[FLG_V];
  assign c_f = flags[FLG_C];
  assign sgn_lt = n_f ^ v_f;

  // each even opcode tests a "clear" condition; the odd neighbour inverts it
  always_comb begin
    base[0] = 1'b1;
    base[1] = ~(c_f | z_f);
    base[2] = ~c_f;
    base[3] = ~z_f;
    base[4] = ~v_f;
    base[5] = ~n_f;
    base[6] = ~sgn_lt;
    base[7] = ~(z_f | sgn_lt);
  end

  assign is_rel = (opcode[7:4] == REL_GROUP);
  assign is_sub = (opcode == SUBR_OP);

  always_comb begin
    dec.taken   = is_sub | (is_rel & (base[opcode[3:1]] ^ opcode[0]));
    dec.push    = is_sub;
    dec.invalid = ~(is_rel | is_sub);
  end
endmodule

// File: rtl/brc_target_add.sv
module brc_target_add #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   target
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] disp_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_ext = disp[PC_W-1:0];
    end
  endgenerate

  // wraps modulo 2^PC_W by width truncation
  assign target = pc + disp_ext;
endmodule

// File: rtl/brc_out_stage.sv
module brc_out_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PAY_W-1:0] up_data,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PAY_W-1:0] dn_data
);
  logic             vld_q;
  logic [PAY_W-1:0] dat_q;

  assign up_ready = ~vld_q | dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (up_valid && up_ready) begin
      vld_q <= 1'b1;
      dat_q <= up_data;
    end else if (dn_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign dn_valid = vld_q;
  assign dn_data  = dat_q;
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
  import brc_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_opcode,
  input  logic [FLG_W-1:0]  in_flags,
  input  logic [PC_W-1:0]   in_pc,
  input  logic [DISP_W-1:0] in_disp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [PC_W-1:0]   out_next_pc,
  output logic              out_push,
  output logic [PC_W-1:0]   out_ret_addr,
  output logic              out_invalid
);
  localparam int PAY_W = 3 + 2 * PC_W;

  brc_decision_t   dec;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] next_pc;
  logic [PAY_W-1:0] pay_in, pay_out;

  brc_cond_eval #(.OP_W(OP_W)) u_cond (
    .opcode (in_opcode),
    .flags  (in_flags),
    .dec    (dec)
  );

  brc_target_add #(.PC_W(PC_W), .DISP_W(DISP_W)) u_add (
    .pc     (in_pc),
    .disp   (in_disp),
    .target (target)
  );

  assign next_pc = dec.taken ? target : in_pc;
  assign pay_in  = {dec.taken, dec.push, dec.invalid, next_pc, in_pc};

  brc_out_stage #(.PAY_W(PAY_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign {out_taken, out_push, out_invalid, out_next_pc, out_ret_addr} = pay_out;
endmodule

// File: rtl/rel_branch_unit_checker.sv
module rel_branch_unit_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_taken,
  input logic [PC_W-1:0] out_next_pc,
  input logic            out_push,
  input logic [PC_W-1:0] out_ret_addr,
  input logic            out_invalid
);
  // R9: stalled result holds
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_taken) && $stable(out_push)
      && $stable(out_invalid) && $stable(out_next_pc) && $stable(out_ret_addr)));

  // R9: accepted request appears at the output next cycle
  a_r9_accept_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8: invalid opcodes neither branch nor push
  a_r8_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (!out_taken && !out_push && out_next_pc == out_ret_addr));

  // R7: a push request is always a taken branch
  a_r7_push_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_push) |-> (out_taken && !out_invalid));

  // R2: not taken falls through to the post-displacement PC
  a_r2_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_taken) |-> (out_next_pc == out_ret_addr));

  // R10: reset empties the output
  a_r10_reset_empty: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind rel_branch_unit rel_branch_unit_checker #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_taken    (out_taken),
  .out_next_pc  (out_next_pc),
  .out_push     (out_push),
  .out_ret_addr (out_ret_addr),
  .out_invalid  (out_invalid)
);

// File: tb/rel_branch_unit_test.sv
`timescale 1ns/1ps
module rel_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0;
  logic [3:0]  in_flags = '0;
  logic [15:0] in_pc = '0;
  logic [7:0]  in_disp = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_taken;
  logic [15:0] out_next_pc;
  logic        out_push;
  logic [15:0] out_ret_addr;
  logic        out_invalid;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit rdy_rand = 1'b0;

  // expected: {taken, push, invalid, next_pc, ret}
  logic [34:0] exp_q[$];
  logic [34:0] held;
  bit          held_ok = 1'b0;

  always #5 clk = ~clk;

  rel_branch_unit uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_flags(in_flags), .in_pc(in_pc), .in_disp(in_disp),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_next_pc(out_next_pc), .out_push(out_push),
    .out_ret_addr(out_ret_addr), .out_invalid(out_invalid)
  );

  function automatic logic [34:0] model(input logic [7:0] op, input logic [3:0] f,
                                        input logic [15:0] pc, input logic [7:0] d);
    logic n, z, v, c, t, p, inv;
    logic [15:0] tgt;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    t = 1'b0; p = 1'b0; inv = 1'b0;
    case (op)
      8'h20: t = 1'b1;            // R3
      8'h21: t = 1'b0;            // R3
      8'h22: t = !(c || z);       // R4
      8'h23: t = c || z;
      8'h24: t = !c;
      8'h25: t = c;
      8'h26: t = !z;              // R5
      8'h27: t = z;
      8'h28: t = !v;
      8'h29: t = v;
      8'h2A: t = !n;
      8'h2B: t = n;
      8'h2C: t = (n == v);        // R6
      8'h2D: t = (n != v);
      8'h2E: t = !z && (n == v);
      8'h2F: t = z || (n != v);
      8'h8D: begin t = 1'b1; p = 1'b1; end  // R7
      default: inv = 1'b1;        // R8
    endcase
    tgt = 16'(int'(pc) + int'($signed(d)));  // R1
    return {t, p, inv, (t ? tgt : pc), pc};  // R2
  endfunction

  task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [34:0] e, input logic [7:0] op);
    if (e[32]) return "R8";
    if (op == 8'h8D) return "R7";
    if (op[3:1] == 3'd0) return "R3";
    if (op[3:1] <= 3'd2) return "R4";
    if (op[3:1] <= 3'd5) return "R5";
    return "R6";
  endfunction

  logic [7:0] op_q[$];

  // monitor: evaluated after inputs settle, well before the next edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      cycles++;
      if (held_ok) begin
        // R9: stalled output unchanged
        check("R9", {out_valid, out_taken, out_push, out_invalid, out_next_pc, out_ret_addr},
              {1'b1, held});
        held_ok = 1'b0;
      end
      check("R9", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check("R9", 35'd1, 35'd0);
        else begin
          logic [34:0] e;
          logic [7:0] o;
          e = exp_q.pop_front();
          o = op_q.pop_front();
          check(req_of(e, o), {out_taken, out_push, out_invalid, out_next_pc, out_ret_addr}, e);
        end
      end else if (out_valid) begin
        held = {out_taken, out_push, out_invalid, out_next_pc, out_ret_addr};
        held_ok = 1'b1;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_opcode, in_flags, in_pc, in_disp));
        op_q.push_back(in_opcode);
      end
    end
  end

  // consumer: random back-pressure once enabled
  always @(negedge clk) begin
    if (rdy_rand) out_ready <= ($urandom % 4) != 0;
  end

  task automatic send(input logic [7:0] op, input logic [3:0] f,
                      input logic [15:0] pc, input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_opcode = op; in_flags = f; in_pc = pc; in_disp = d;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    #1;
    check("R10", {34'd0, out_valid}, 35'd0);   // R10 during reset
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10", {34'd0, out_valid}, 35'd0);   // R10 after reset
    out_ready = 1'b1;
    // every branch opcode against every flag pattern (R3..R7)
    for (int o = 0; o < 16; o++)
      for (int fl = 0; fl < 16; fl++)
        send(8'h20 + 8'(o), 4'(fl), 16'h4000 + 16'(fl), 8'(o * 9));
    for (int fl = 0; fl < 16; fl += 5) send(8'h8D, 4'(fl), 16'h1234, 8'hF0);
    // wrap corners (R1)
    send(8'h20, 4'h0, 16'hFFF0, 8'h7F);
    send(8'h20, 4'h0, 16'h0005, 8'h80);
    send(8'h8D, 4'h0, 16'hFFFF, 8'h01);
    // invalid neighbours (R8)
    send(8'h1F, 4'hF, 16'h2222, 8'h10);
    send(8'h30, 4'h0, 16'h3333, 8'h10);
    send(8'h8C, 4'h0, 16'h4444, 8'h10);
    send(8'h8E, 4'h0, 16'h5555, 8'h10);
    // random traffic with back-pressure and idle gaps (R9)
    rdy_rand = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] op;
      case ($urandom % 4)
        0: op = 8'($urandom);
        1: op = 8'h8D;
        default: op = 8'h20 + 8'($urandom % 16);
      endcase
      if (($urandom % 5) == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
      send(op, 4'($urandom), 16'($urandom), 8'($urandom));
    end
    @(negedge clk); in_valid = 1'b0;
    rdy_rand = 1'b0;
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    #3;
    check("R9", {3'd0, 32'(exp_q.size())}, 35'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule